// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a general-purpose I/O controller for up to sixteen pins (twelve by default) that software accesses through a word-addressed 32-bit register port. Every pin has a direction bit and an output latch. Its input passes through a two-flop synchronizer before it can be read back. Each pin also has its own interrupt detector. The detector can be set to trigger on a falling edge, a rising edge, either edge, a low level or a high level.

Detected events set a per-pin status bit, but only on pins that are enabled. Edge events stay latched until software clears them. A level event is set again on every cycle that the level persists. A mask register is changed through separate write-one-to-set and write-one-to-clear words. It gates the status bits into a single combined interrupt line.

A small state machine implements the soft reset word. It has two states, RUN and HOLD. The ENTER transition (RUN to HOLD) happens on a write of 1 to bit 0 of the reset word. The RELEASE transition (HOLD to RUN) happens on a write of 0 to that bit. The edge that takes ENTER, every edge spent in HOLD, and the edge that takes RELEASE all force configuration and status back to their reset values.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset all pins are inputs (pin_oe = 0), pin_out = 0, all enables are 0, all mask bits are 1, all status is 0 and irq is 0.
- R2: pin_oe follows the direction word (1 = drive) and pin_out follows the output data word. In every register, bits at or above N_PINS read as 0 and are ignored on write.
- R3: The input data word returns pin_in delayed by two clock edges through the synchronizer. A value that has crossed only one edge is not yet visible.
- R4: Mode codes 0 (falling), 1 (rising) and 4 (either edge) compare the current synchronized sample with the previous one. Each latches a status bit that stays set until it is cleared.
- R5: Mode codes 2 (level low) and 3 (level high) set status on every cycle that the level is present. A clear issued while the level persists leaves the bit set.
- R6: Mode codes 5, 6 and 7 never set status.
- R7: A status bit can only become set on a pin whose enable bit is 1.
- R8: A 1 written to a mask-set bit masks that pin, and a 1 written to a mask-clear bit unmasks it. Zero bits change nothing. Both words read back the mask.
- R9: A 1 written to a bit of the clear word clears that status bit. Zero bits leave status unchanged, and the clear word reads 0.
- R10: irq is the OR of the status bits that are unmasked. The display word returns status AND NOT mask.
- R11: Pin p below 8 takes its mode from bits 4p+2..4p of mode word 0. Pin p of 8 or above takes it from bits 4(p-8)+2..4(p-8) of mode word 1. The fourth bit of each nibble is ignored and reads 0.
- R12: Writing 1 to bit 0 of the reset word enters HOLD. In HOLD, configuration and status sit at their R1 values, other writes are ignored, and the reset word reads 1. Writing 0 returns to RUN.
- R13: Word addresses: enable 0, status 1, display 2, clear 3, mask-set 4, mask-clear 5, output data 6, input data 7, direction 8, mode 0 9, mode 1 10, reset 15. Words 11 to 14 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_word |
| pin_in | input | N_PINS | Raw pin levels |
| pin_out | output | N_PINS | Output latch value |
| pin_oe | output | N_PINS | Drive enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the latency of the synchronizer plus the status register. A design one flop short would raise status a cycle early, and one a flop long would read back stale inputs. It clears a level-high pin while the level is still present; a design that treated levels as sticky edges would drop the bit and lose the interrupt. It programs nibbles whose fourth bit is set and uses codes 5 and 7, which exposes a decoder that reads four bits or maps reserved codes onto an edge mode. It also writes during HOLD, which a design would wrongly accept if it cleared only on the ENTER edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // detector codes per pin
    typedef enum logic [2:0] {
        DET_FALL = 3'd0,
        DET_RISE = 3'd1,
        DET_LOW  = 3'd2,
        DET_HIGH = 3'd3,
        DET_ANY  = 3'd4
    } det_mode_e;

    // soft reset controller states
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } srst_state_e;

    // register word indices (software decodes these)
    localparam logic [3:0] W_IEN   = 4'd0;
    localparam logic [3:0] W_STAT  = 4'd1;
    localparam logic [3:0] W_DISP  = 4'd2;
    localparam logic [3:0] W_CLR   = 4'd3;
    localparam logic [3:0] W_MSET  = 4'd4;
    localparam logic [3:0] W_MCLR  = 4'd5;
    localparam logic [3:0] W_DOUT  = 4'd6;
    localparam logic [3:0] W_DIN   = 4'd7;
    localparam logic [3:0] W_DIR   = 4'd8;
    localparam logic [3:0] W_MODE0 = 4'd9;
    localparam logic [3:0] W_MODE1 = 4'd10;
    localparam logic [3:0] W_SRST  = 4'd15;

    localparam int PINS_PER_MODE_WORD = 8;
    localparam int MODE_NIBBLE        = 4;

endpackage

// File: rtl/gpio_sync_stage.sv
module gpio_sync_stage #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] smp_now,
    output logic [W-1:0] smp_prev
);

    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    // one more sample for edge comparison
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_prev <= '0;
        else        smp_prev <= chain[STAGES-1];
    end

    assign smp_now = chain[STAGES-1];

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_clr,
    input  logic       mode_we,
    input  logic [2:0] mode_wd,
    input  logic       smp_now,
    input  logic       smp_prev,
    output logic [2:0] mode_q,
    output logic       hit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= 3'd0;
        else if (cfg_clr) mode_q <= 3'd0;
        else if (mode_we) mode_q <= mode_wd;
    end

    always_comb begin
        hit = 1'b0;
        case (mode_q)
            DET_FALL: hit = smp_prev & ~smp_now;
            DET_RISE: hit = ~smp_prev & smp_now;
            DET_LOW:  hit = ~smp_now;
            DET_HIGH: hit = smp_now;
            DET_ANY:  hit = smp_prev ^ smp_now;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_soft_rst_fsm.sv
module gpio_soft_rst_fsm
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rst_wr,
    input  logic rst_bit,
    output logic hold,
    output logic cfg_clr
);

    srst_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (rst_wr && rst_bit)  state_d = ST_HOLD; // ENTER
            ST_HOLD: if (rst_wr && !rst_bit) state_d = ST_RUN;  // RELEASE
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        hold    = 1'b0;
        cfg_clr = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                hold    = 1'b0;
                cfg_clr = rst_wr && rst_bit;
            end
            ST_HOLD: begin
                hold    = 1'b1;
                cfg_clr = 1'b1;
            end
            default: begin
                hold    = 1'b0;
                cfg_clr = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_word,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq
);

    localparam logic [N_PINS-1:0] ALL_ONES = {N_PINS{1'b1}};

    logic [N_PINS-1:0] en_q, mask_q, stat_q, out_q, dir_q;
    logic [N_PINS-1:0] smp_now, smp_prev, hit, stat_set;
    logic [N_PINS-1:0] wbits;
    logic [2:0]        mode_arr [N_PINS];
    logic [31:0]       mode0_rd, mode1_rd;
    logic              hold, cfg_clr;
    logic              unused_wdata;

    assign wbits        = reg_wdata[N_PINS-1:0];
    assign unused_wdata = ^reg_wdata;

    // soft reset controller
    gpio_soft_rst_fsm u_srst (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_wr  (reg_wr && (reg_word == W_SRST)),
        .rst_bit (reg_wdata[0]),
        .hold    (hold),
        .cfg_clr (cfg_clr)
    );

    // input synchronizer
    gpio_sync_stage #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (pin_in),
        .smp_now  (smp_now),
        .smp_prev (smp_prev)
    );

    // per-pin mode storage and detection
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        localparam bit IN_LO = (p < PINS_PER_MODE_WORD);
        localparam int SUB   = IN_LO ? p : p - PINS_PER_MODE_WORD;
        localparam logic [3:0] MY_WORD = IN_LO ? W_MODE0 : W_MODE1;
        logic       we;
        logic [2:0] wd;
        assign we = reg_wr && !cfg_clr && (reg_word == MY_WORD);
        assign wd = reg_wdata[MODE_NIBBLE*SUB +: 3];
        gpio_pin_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_clr  (cfg_clr),
            .mode_we  (we),
            .mode_wd  (wd),
            .smp_now  (smp_now[p]),
            .smp_prev (smp_prev[p]),
            .mode_q   (mode_arr[p]),
            .hit      (hit[p])
        );
    end

    assign stat_set = hit & en_q;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= ALL_ONES;
            out_q  <= '0;
            dir_q  <= '0;
        end else if (cfg_clr) begin
            en_q   <= '0;
            mask_q <= ALL_ONES;
            out_q  <= '0;
            dir_q  <= '0;
        end else if (reg_wr) begin
            case (reg_word)
                W_IEN:   en_q   <= wbits;
                W_MSET:  mask_q <= mask_q | wbits;
                W_MCLR:  mask_q <= mask_q & ~wbits;
                W_DOUT:  out_q  <= wbits;
                W_DIR:   dir_q  <= wbits;
                default: ;
            endcase
        end
    end

    // status: clear first, new events win
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (cfg_clr) begin
            stat_q <= '0;
        end else if (reg_wr && (reg_word == W_CLR)) begin
            stat_q <= (stat_q & ~wbits) | stat_set;
        end else begin
            stat_q <= stat_q | stat_set;
        end
    end

    // mode read-back packing
    always_comb begin
        mode0_rd = '0;
        mode1_rd = '0;
        for (int p = 0; p < N_PINS; p++) begin
            if (p < PINS_PER_MODE_WORD)
                mode0_rd[MODE_NIBBLE*p +: 3] = mode_arr[p];
            else
                mode1_rd[MODE_NIBBLE*(p-PINS_PER_MODE_WORD) +: 3] = mode_arr[p];
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_word)
            W_IEN:   reg_rdata[N_PINS-1:0] = en_q;
            W_STAT:  reg_rdata[N_PINS-1:0] = stat_q;
            W_DISP:  reg_rdata[N_PINS-1:0] = stat_q & ~mask_q;
            W_MSET,
            W_MCLR:  reg_rdata[N_PINS-1:0] = mask_q;
            W_DOUT:  reg_rdata[N_PINS-1:0] = out_q;
            W_DIN:   reg_rdata[N_PINS-1:0] = smp_now;
            W_DIR:   reg_rdata[N_PINS-1:0] = dir_q;
            W_MODE0: reg_rdata = mode0_rd;
            W_MODE1: reg_rdata = mode1_rd;
            W_SRST:  reg_rdata[0] = hold;
            default: reg_rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |(stat_q & ~mask_q);

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [3:0]        reg_word,
    input logic [31:0]       reg_wdata,
    input logic              irq,
    input logic [N_PINS-1:0] pin_oe,
    input logic [N_PINS-1:0] en_q,
    input logic [N_PINS-1:0] mask_q,
    input logic [N_PINS-1:0] stat_q,
    input logic [N_PINS-1:0] stat_set,
    input logic              hold
);

    localparam logic [N_PINS-1:0] ONES = {N_PINS{1'b1}};

    AST_STAT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0)); // R7

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_word == W_MSET) |=>
        ((mask_q & $past(reg_wdata[N_PINS-1:0])) == $past(reg_wdata[N_PINS-1:0]))); // R8

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_word == W_MCLR && !hold) |=>
        ((mask_q & $past(reg_wdata[N_PINS-1:0])) == '0)
        && ((mask_q & ~$past(reg_wdata[N_PINS-1:0]))
            == ($past(mask_q) & ~$past(reg_wdata[N_PINS-1:0])))); // R8

    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_word == W_CLR && reg_wdata[N_PINS-1:0] == ONES
         && stat_set == '0) |=> (stat_q == '0)); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == ONES) |-> !irq); // R10

    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (en_q == '0 && stat_q == '0 && mask_q == ONES && pin_oe == '0)); // R12

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N_PINS(N_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_word  (reg_word),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .pin_oe    (pin_oe),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .stat_set  (stat_set),
    .hold      (hold)
);

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;

    localparam int N = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [3:0]    reg_word = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.N_PINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [N-1:0] m_s1, m_s2, m_prev, m_en, m_mask, m_stat, m_out, m_dir, hits;
    int  m_mode [N];
    bit  m_hold, sr;
    int  w;

    function automatic int code_of(int p);
        return m_mode[p];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_en = '0; m_mask = '1;
            m_stat = '0; m_out = '0; m_dir = '0; m_hold = 0;
            for (int p = 0; p < N; p++) m_mode[p] = 0;
        end else begin
            for (int p = 0; p < N; p++) begin
                case (code_of(p))
                    0: hits[p] = m_prev[p] && !m_s2[p];
                    1: hits[p] = !m_prev[p] && m_s2[p];
                    2: hits[p] = !m_s2[p];
                    3: hits[p] = m_s2[p];
                    4: hits[p] = m_prev[p] != m_s2[p];
                    default: hits[p] = 0;
                endcase
            end
            w  = int'(reg_word);
            sr = m_hold || (reg_wr && w == 15 && reg_wdata[0]);
            if (reg_wr && w == 15) m_hold = reg_wdata[0];
            if (sr) begin
                m_en = '0; m_mask = '1; m_stat = '0; m_out = '0; m_dir = '0;
                for (int p = 0; p < N; p++) m_mode[p] = 0;
            end else begin
                if (reg_wr && w == 3) m_stat = m_stat & ~reg_wdata[N-1:0];
                m_stat = m_stat | (hits & m_en);
                if (reg_wr) begin
                    case (w)
                        0: m_en   = reg_wdata[N-1:0];
                        4: m_mask = m_mask | reg_wdata[N-1:0];
                        5: m_mask = m_mask & ~reg_wdata[N-1:0];
                        6: m_out  = reg_wdata[N-1:0];
                        8: m_dir  = reg_wdata[N-1:0];
                        9:  for (int p = 0; p < 8; p++) m_mode[p] = int'((reg_wdata >> (4*p)) & 32'h7);
                        10: for (int p = 8; p < N; p++) m_mode[p] = int'((reg_wdata >> (4*(p-8))) & 32'h7);
                        default: ;
                    endcase
                end
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    function automatic logic [31:0] model_read(int wd);
        logic [31:0] r = '0;
        case (wd)
            0: r[N-1:0] = m_en;
            1: r[N-1:0] = m_stat;
            2: r[N-1:0] = m_stat & ~m_mask;
            4, 5: r[N-1:0] = m_mask;
            6: r[N-1:0] = m_out;
            7: r[N-1:0] = m_s2;
            8: r[N-1:0] = m_dir;
            9:  for (int p = 0; p < 8; p++) r = r | (32'(m_mode[p]) << (4*p));
            10: for (int p = 8; p < N; p++) r = r | (32'(m_mode[p]) << (4*(p-8)));
            15: r[0] = m_hold;
            default: r = '0;
        endcase
        return r;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of outputs against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R10 irq", 32'(irq), 32'(|(m_stat & ~m_mask)));
            check("R2 pin_oe", 32'(pin_oe), 32'(m_dir));
            check("R2 pin_out", 32'(pin_out), 32'(m_out));
        end
    end

    task automatic wr(int wd, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_word = 4'(wd); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_model(int wd, string tag);
        @(negedge clk);
        reg_word = 4'(wd);
        #1;
        check(tag, reg_rdata, model_read(wd));
    endtask

    task automatic rd_exp(int wd, logic [31:0] exp, logic [31:0] msk, string tag);
        @(negedge clk);
        reg_word = 4'(wd);
        #1;
        check(tag, reg_rdata & msk, exp);
        check(tag, reg_rdata, model_read(wd));
    endtask

    task automatic drive(logic [N-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1;
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_exp(4, 32'h0000_0FFF, 32'hFFFF_FFFF, "R1 mask after reset");
        rd_exp(1, 32'h0, 32'hFFFF_FFFF, "R1 status after reset");
        rd_exp(8, 32'h0, 32'hFFFF_FFFF, "R1 direction after reset");
        rd_exp(0, 32'h0, 32'hFFFF_FFFF, "R1 enable after reset");
        check("R1 irq after reset", 32'(irq), 32'h0);

        // R2 direction and output, upper bits dropped
        wr(8, 32'hFFFF_FFFF);
        rd_exp(8, 32'h0000_0FFF, 32'hFFFF_FFFF, "R2 direction upper bits");
        wr(6, 32'hFFFF_F5A5);
        rd_exp(6, 32'h0000_05A5, 32'hFFFF_FFFF, "R2 output data");
        wr(8, 32'h0);

        // R3 synchronizer latency
        drive(12'hABC);
        rd_exp(7, 32'h0, 32'hFFFF_FFFF, "R3 input after one edge");
        rd_exp(7, 32'h0000_0ABC, 32'hFFFF_FFFF, "R3 input after two edges");
        drive(12'h000);
        idle(4);

        // R11 mode field placement, fourth nibble bit ignored
        wr(9, 32'h9F5C_BA98);
        rd_exp(9, 32'h1754_3210, 32'hFFFF_FFFF, "R11 mode word 0");
        wr(10, 32'hFFFF_3C09);
        rd_exp(10, 32'h0000_3401, 32'hFFFF_FFFF, "R11 mode word 1");
        rd_exp(13, 32'h0, 32'hFFFF_FFFF, "R13 reserved word");

        // enable all but pin 7, unmask all
        wr(0, 32'h0000_0F7F);
        wr(5, 32'h0000_0FFF);
        wr(3, 32'h0000_0FFF);

        // rising: pins 1 (rise), 4 (any), 8 (rise), 10 (any), 3/11 level high
        drive(12'hFFF);
        idle(3);
        rd_model(1, "R4 status after rise");
        rd_exp(1, 32'h0000_0002, 32'h0000_0002, "R4 rising edge latched");
        rd_exp(1, 32'h0, 32'h0000_0080, "R7 disabled pin 7 not latched");
        rd_exp(1, 32'h0, 32'h0000_0060, "R6 codes 5 and 7 ignored");
        rd_model(2, "R10 display word");
        wr(3, 32'h0000_0FFF);
        rd_exp(1, 32'h0000_0808, 32'hFFFF_FFFF, "R5 level high survives clear");

        // falling: pin 0, pin 9, both-edge pins; pin 1 sticky check after clear
        drive(12'h000);
        idle(3);
        rd_model(1, "R4 status after fall");
        rd_exp(1, 32'h0000_0211, 32'h0000_0211, "R4 falling and either edge");
        wr(3, 32'h0000_0FFF);
        drive(12'hFFF);
        idle(3);
        drive(12'h000);
        idle(3);
        rd_exp(1, 32'h0000_0002, 32'h0000_0002, "R4 rising stays latched after fall");

        // mixed patterns against the model
        drive(12'hA5A); idle(3); rd_model(1, "R4 pattern A5A");
        wr(3, 32'h0000_0000);
        rd_model(1, "R9 zero clear keeps status");
        drive(12'h5A5); idle(3); rd_model(1, "R4 pattern 5A5");
        wr(3, 32'h0000_0005);
        rd_model(1, "R9 partial clear");
        drive(12'h0F0); idle(3); rd_model(2, "R10 display pattern 0F0");

        // R8 mask set/clear
        wr(3, 32'h0000_0FFF);
        wr(4, 32'h0000_0F0F);
        rd_exp(4, 32'h0000_0F0F, 32'hFFFF_FFFF, "R8 mask set");
        wr(4, 32'h0);
        wr(5, 32'h0);
        rd_exp(5, 32'h0000_0F0F, 32'hFFFF_FFFF, "R8 zero writes no effect");
        wr(5, 32'h0000_0003);
        rd_exp(4, 32'h0000_0F0C, 32'hFFFF_FFFF, "R8 mask clear");
        drive(12'hFFF); idle(3);
        rd_model(2, "R10 display with partial mask");
        wr(4, 32'h0000_0FFF);
        idle(2);
        check("R10 irq quiet when fully masked", 32'(irq), 32'h0);

        // R12 soft reset hold
        wr(8, 32'h0000_0055);
        wr(15, 32'h1);
        wr(8, 32'h0000_0FFF);
        wr(0, 32'h0000_0FFF);
        rd_exp(8, 32'h0, 32'hFFFF_FFFF, "R12 direction write ignored in hold");
        rd_exp(15, 32'h1, 32'hFFFF_FFFF, "R12 reset word reads hold");
        rd_exp(4, 32'h0000_0FFF, 32'hFFFF_FFFF, "R12 mask reset in hold");
        rd_exp(9, 32'h0, 32'hFFFF_FFFF, "R12 modes reset in hold");
        wr(15, 32'h0);
        rd_exp(15, 32'h0, 32'hFFFF_FFFF, "R12 released");
        wr(8, 32'h0000_000F);
        rd_exp(8, 32'h0000_000F, 32'hFFFF_FFFF, "R12 writes accepted after release");
        rd_exp(1, 32'h0, 32'hFFFF_FFFF, "R12 status clear after release");

        idle(3);
        done = 1;
        summary();
        $finish;
    end

endmodule